// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block produces the programmed-I/O read and write strobes for an IDE channel that carries two drives. Every access the host requests runs through three timed phases: an address-setup phase, an active pulse in which the strobe is driven, and a recovery phase. The controller counts bus clocks for each phase, then returns to idle and takes the next request.

The timing is held in a small register file. Each drive has one timing byte for reads and one for writes. Each byte packs the pulse length and the recovery length as offsets from their minimum values. One shared byte carries the address-setup length for both drives, so software has to program it for the slower drive. A bank bit on the configuration port picks the drive whose set a write updates. The drive-select bit of a request picks the set that the access uses. At the moment a request is accepted the controller takes a copy of the counts it needs. A register write made while an access is running therefore changes only later accesses.

The state machine has four states. ST_IDLE moves to ST_SETUP when a request is accepted. ST_SETUP moves to ST_PULSE when the setup count runs out. ST_PULSE moves to ST_RECOVER when the pulse count runs out. ST_RECOVER moves back to ST_IDLE when the recovery count runs out. Every other cycle is spent counting down in the current state.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, busy, rd_strobe, wr_strobe and req_ack are low, and every timing field is zero. A first access then lasts 1 setup clock, 1 pulse clock and 2 recovery clocks.
- R2: The address-setup phase lasts (cfg_data[5:4] + 1) clocks. The value comes from the shared byte written with cfg_addr = 2, and it applies to accesses on both drives whatever cfg_bank was during that write.
- R3: The strobe is high for (byte[7:4] + 1) consecutive clocks, where byte is the timing byte that the access uses.
- R4: After the strobe falls, busy stays high for (byte[3:0] + 2) clocks of recovery.
- R5: A read (req_write = 0) uses the read timing byte (cfg_addr = 0) and pulses only rd_strobe. A write (req_write = 1) uses the write timing byte (cfg_addr = 1) and pulses only wr_strobe.
- R6: A timing write with cfg_bank = d updates only drive d's set, and an access with req_drive = d uses only drive d's set.
- R7: req_ack is high only while idle and req_valid is high. busy rises on the clock that accepts a request and stays high until recovery ends. A request held during busy is acknowledged in the first idle cycle.
- R8: A timing write made while an access is in progress does not change that access. It applies from the next accepted access on.
- R9: A strobe is high only during the pulse phase of a busy cycle, and rd_strobe and wr_strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_addr | input | 2 | 0 read timing, 1 write timing, 2 shared setup byte |
| cfg_bank | input | 1 | Drive whose set a timing write updates |
| cfg_data | input | 8 | Timing byte to write |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write access, 0 for read |
| req_drive | input | 1 | Drive the access addresses |
| req_ack | output | 1 | Request accepted on this clock |
| busy | output | 1 | Access in progress |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |

## Verification
The bench measures each access phase by phase and compares the result with the fields the bench itself wrote. It covers the extreme fields 0x00 and 0xFF, where an off-by-one in the minimum offsets shows up as a pulse of 0 or 17 clocks or a recovery of 1 or 18 clocks. It drives cross-bank and cross-direction patterns, which show a design that reads the wrong set, or that applies a write meant for one drive to the other. It also rewrites a register in the middle of an access, which a design without the snapshot would let stretch the running pulse. It holds a request during busy as well, which catches a design that acknowledges early or loses the waiting request.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PULSE_W = 4;
    localparam int REC_W   = 4;
    localparam int SETUP_W = 2;
    localparam int CNT_W   = REC_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_RECOVER
    } pio_state_e;

    typedef struct packed {
        logic [PULSE_W-1:0] pulse_m1;
        logic [REC_W-1:0]   rec_m2;
    } cyc_t;
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_pkg::*;
#(
    parameter int DRV_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [DRV_W-1:0]   cfg_bank,
    input  logic [7:0]         cfg_data,
    input  logic [DRV_W-1:0]   lk_drive,
    input  logic               lk_write,
    output cyc_t               lk_cyc,
    output logic [SETUP_W-1:0] setup_m1
);
    localparam int NUM_DRV = 1 << DRV_W;

    cyc_t rd_q [NUM_DRV];
    cyc_t wr_q [NUM_DRV];

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q[g] <= '0;
                wr_q[g] <= '0;
            end else if (cfg_we && cfg_bank == DRV_W'(g)) begin
                if (cfg_addr == 2'd0) rd_q[g] <= cyc_t'(cfg_data);
                if (cfg_addr == 2'd1) wr_q[g] <= cyc_t'(cfg_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            setup_m1 <= '0;
        else if (cfg_we && cfg_addr == 2'd2)
            setup_m1 <= cfg_data[5:4];
    end

    always_comb begin
        lk_cyc = lk_write ? wr_q[lk_drive] : rd_q[lk_drive];
    end
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  cyc_t               lk_cyc,
    input  logic [SETUP_W-1:0] setup_m1,
    output logic               req_ack,
    output logic               busy,
    output logic               rd_strobe,
    output logic               wr_strobe
);
    pio_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    cyc_t             snap_q;
    logic             dir_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q - CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = cnt_q;
                if (req_valid) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(setup_m1);
                end
            end
            ST_SETUP: if (cnt_q == '0) begin
                state_d = ST_PULSE;
                cnt_d   = CNT_W'(snap_q.pulse_m1);
            end
            ST_PULSE: if (cnt_q == '0) begin
                state_d = ST_RECOVER;
                cnt_d   = CNT_W'(snap_q.rec_m2) + CNT_W'(1);
            end
            ST_RECOVER: if (cnt_q == '0) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            snap_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                snap_q <= lk_cyc;
                dir_q  <= req_write;
            end
        end
    end

    always_comb begin
        req_ack   = accept;
        busy      = (state_q != ST_IDLE);
        rd_strobe = (state_q == ST_PULSE) && !dir_q;
        wr_strobe = (state_q == ST_PULSE) && dir_q;
    end

    p_excl_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));
    p_strobe_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> busy);
    p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !busy);
    p_busy_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy);
    p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |-> $past(busy));
    p_recover_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_strobe || wr_strobe) |-> busy);
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(snap_q) && $stable(dir_q)));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_addr,
    input  logic       cfg_bank,
    input  logic [7:0] cfg_data,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_drive,
    output logic       req_ack,
    output logic       busy,
    output logic       rd_strobe,
    output logic       wr_strobe
);
    cyc_t               lk_cyc;
    logic [SETUP_W-1:0] setup_m1;

    pio_timing_regs #(.DRV_W(1)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_bank (cfg_bank),
        .cfg_data (cfg_data),
        .lk_drive (req_drive),
        .lk_write (req_write),
        .lk_cyc   (lk_cyc),
        .setup_m1 (setup_m1)
    );

    pio_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .lk_cyc    (lk_cyc),
        .setup_m1  (setup_m1),
        .req_ack   (req_ack),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );
endmodule

// File: tb/pio_strobe_gen_bench.sv
module pio_strobe_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic       cfg_bank = 1'b0;
    logic [7:0] cfg_data = 8'd0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_ack, busy, rd_strobe, wr_strobe;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_rd [2];
    logic [7:0] m_wr [2];
    logic [7:0] m_misc;

    always #4 clk = ~clk;

    pio_strobe_gen u_pio_strobe_gen (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic int exp_setup();
        return int'(m_misc[5:4]) + 1;
    endfunction
    function automatic int exp_pulse(input logic [7:0] b);
        return int'(b[7:4]) + 1;
    endfunction
    function automatic int exp_rec(input logic [7:0] b);
        return int'(b[3:0]) + 2;
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic bank, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_bank = bank; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) m_rd[bank] = d;
        else if (a == 2'd1) m_wr[bank] = d;
        else if (a == 2'd2) m_misc = d;
    endtask

    // mid: rewrite this access's timing byte during the access (R8)
    // hold: keep a second request pending during busy (R7)
    task automatic access(input logic drv, input logic wr, input bit mid,
                          input bit hold, input string tag);
        logic [7:0] b;
        int s, p, r, wrong, gap, it;
        bit seen;
        b = wr ? m_wr[drv] : m_rd[drv];
        s = 0; p = 0; r = 0; wrong = 0; gap = 0; seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_drive = drv;
        #1;
        chk({tag, " R7 ack when idle"}, int'(req_ack), 1);
        @(posedge clk);
        #1;
        if (!hold) req_valid = 1'b0;
        for (it = 0; it < 60; it++) begin
            @(negedge clk);
            if (mid && it == 0) begin
                cfg_we = 1'b1; cfg_addr = wr ? 2'd1 : 2'd0; cfg_bank = drv;
                cfg_data = ~b;
            end
            if (mid && it == 1) begin
                cfg_we = 1'b0;
                if (wr) m_wr[drv] = ~b; else m_rd[drv] = ~b;
            end
            if (!busy) break;
            if (hold && req_ack) gap++;
            if ((wr && rd_strobe) || (!wr && wr_strobe)) wrong++;
            if (rd_strobe || wr_strobe) begin
                if (r != 0) wrong++;
                seen = 1; p++;
            end else if (!seen) s++;
            else r++;
        end
        if (it == 60) chk({tag, " watchdog access end"}, 0, 1);
        chk({tag, " R2 setup clocks"}, s, exp_setup());
        chk({tag, " R3 pulse clocks"}, p, exp_pulse(b));
        chk({tag, " R4 recovery clocks"}, r, exp_rec(b));
        chk({tag, " R5 R9 strobe choice"}, wrong, 0);
        if (hold) begin
            chk({tag, " R7 no ack while busy"}, gap, 0);
            chk({tag, " R7 ack at first idle"}, int'(req_ack), 1);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        m_rd[0] = 0; m_rd[1] = 0; m_wr[0] = 0; m_wr[1] = 0; m_misc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 rd_strobe after reset", int'(rd_strobe), 0);
        chk("R1 wr_strobe after reset", int'(wr_strobe), 0);
        chk("R1 ack after reset", int'(req_ack), 0);
        access(1'b0, 1'b0, 0, 0, "R1 minima rd d0");
        access(1'b1, 1'b1, 0, 0, "R1 minima wr d1");

        // extremes
        cfg_write(2'd2, 1'b1, 8'h30);
        cfg_write(2'd0, 1'b0, 8'hFF);
        access(1'b0, 1'b0, 0, 0, "R3 R4 max rd d0");
        access(1'b1, 1'b0, 0, 0, "R6 d1 untouched");
        access(1'b0, 1'b1, 0, 0, "R5 wr d0 untouched");
        cfg_write(2'd1, 1'b1, 8'hA5);
        cfg_write(2'd0, 1'b1, 8'h3C);
        access(1'b1, 1'b1, 0, 0, "R5 R6 wr d1");
        access(1'b1, 1'b0, 0, 0, "R5 R6 rd d1");
        access(1'b0, 1'b1, 0, 0, "R6 wr d0 still min");

        // mid-cycle rewrite
        access(1'b0, 1'b0, 1, 0, "R8 mid rewrite");
        access(1'b0, 1'b0, 0, 0, "R8 new value used");

        // request held during busy
        access(1'b1, 1'b1, 0, 1, "R7 held");
        access(1'b0, 1'b0, 0, 0, "R7 after held");

        // random
        for (int k = 0; k < 40; k++) begin
            logic [1:0] a;
            a = 2'($urandom_range(0, 2));
            cfg_write(a, 1'($urandom_range(0, 1)), 8'($urandom));
            access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 3) == 0),
                   "rand R2 R3 R4 R6");
        end
        summary();
    end
endmodule